// File: doc/BRIEF.md
# Timer Channel Trigger and Clock-Gating Front End

This block is the front end of one channel of a general-purpose timer/counter. It runs on the system clock. A qualifying pulse, `cnt_tick`, marks each active edge of whichever counter clock the surrounding logic has chosen. The block holds the channel's up-counter. It decides on which ticks the counter advances, and on which ticks it returns to zero because a trigger has been requested. It also decides whether the two channel I/O lines are driven or sampled, based on the operating mode.

There are four trigger sources:
- a software command;
- a sync pulse shared by all channels;
- a compare match between the counter and a programmable limit value;
- an external event taken from a selectable line.

No trigger acts at once. A request is held until the next tick on which the counter clock is enabled, and the counter is cleared on that tick. Two controls gate the counter clock:
- An enable/disable latch, whose state is reported on `clk_on`. A disable event from elsewhere in the chip also clears it.
- A separate stop hold. A stop event sets it, and it freezes counting until a trigger takes effect.

Top module: `tmr_chan_front`

## Requirements
- R1: During and after a synchronous reset, `cnt` is 0, `clk_on` is 0, and both output enables are 0.
- R2: A `cmd_clk_en` pulse sets `clk_on` on the next cycle. A `cmd_clk_dis` pulse or a `dis_evt` pulse clears it on the next cycle. When an enable and a disable arrive in the same cycle, the disable wins.
- R3: `cnt` goes up by exactly 1 on each cycle where `cnt_tick` is high, `clk_on` is 1, no stop hold is active and no trigger takes effect. It wraps from all-ones to 0. It holds its value in every other cycle without a trigger.
- R4: A `cmd_sw_trig` pulse clears `cnt` to 0 only on the first cycle, counting from the pulse's own cycle, in which both `cnt_tick` and `clk_on` are high. Until that tick, `cnt` is unchanged.
- R5: A `sync_in` pulse behaves exactly like a software trigger, including the deferral.
- R6: When `cmp_en` is 1, a tick that finds `cnt == rc_val` clears `cnt` to 0, so the count runs 0..rc_val repeatedly. When `cmp_en` is 0, the count runs past `rc_val`.
- R7: The external source depends on the mode.
  - In capture mode (`mode_wave`=0), `ext_sel[0]`=0 picks `line_a_in` and `ext_sel[0]`=1 picks `line_b_in`.
  - In waveform mode (`mode_wave`=1), `ext_sel` 0, 1, 2 and 3 pick `line_b_in`, `xc_in[0]`, `xc_in[1]` and `xc_in[2]`.
  - A rising edge of the selected source, after a two-flop synchronizer, requests a trigger only when `ext_en` is 1.
  - Edges on unselected sources have no effect.
- R8: A `stop_evt` pulse freezes `cnt` while ticks continue. The next trigger to take effect clears `cnt` and resumes counting on the ticks that follow.
- R9: One cycle after the mode and select inputs settle, the output enables take these values:
  - In capture mode, both are 0.
  - In waveform mode, `line_a_oe` is 1.
  - In waveform mode, `line_b_oe` is 1 unless `ext_sel` is 0, which selects line B as the external source.
- R10: A trigger requested while `clk_on` is 0 stays pending. It clears `cnt` on the first tick after the clock is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wave | input | 1 | 0 = capture mode, 1 = waveform mode |
| ext_sel | input | 2 | External trigger source select |
| ext_en | input | 1 | External trigger enable |
| cmp_en | input | 1 | Compare-match trigger enable |
| rc_val | input | CNT_W | Compare limit value |
| cmd_clk_en | input | 1 | Counter clock enable command pulse |
| cmd_clk_dis | input | 1 | Counter clock disable command pulse |
| cmd_sw_trig | input | 1 | Software trigger command pulse |
| sync_in | input | 1 | Shared sync pulse, acts as a software trigger |
| stop_evt | input | 1 | Stop event pulse |
| dis_evt | input | 1 | Disable event pulse |
| cnt_tick | input | 1 | Active edge of the selected counter clock |
| line_a_in | input | 1 | Sampled level of I/O line A |
| line_b_in | input | 1 | Sampled level of I/O line B |
| xc_in | input | 3 | Extra external event lines |
| cnt | output | CNT_W | Counter value |
| clk_on | output | 1 | Counter clock status |
| line_a_oe | output | 1 | Drive enable for line A |
| line_b_oe | output | 1 | Drive enable for line B |

## Verification
The hardest case to reach from the ports is an external edge that arrives while the counter clock is quiet. It has to pass through the synchronizer and wait in the pending flag without touching the count. To reach it, the bench parks the counter at a known nonzero value with ticks held low. It then raises one source at a time in every mode and select pairing, lets the synchronizer settle, confirms the count has not moved, and finally issues a single tick. The expected count after that tick is 0 for the selected source and the old count plus one for every other source. The compare limit is swept across several values, and each count is checked against the tick index modulo the limit plus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SRC_A  = 3'd0,
    SRC_B  = 3'd1,
    SRC_X0 = 3'd2,
    SRC_X1 = 3'd3,
    SRC_X2 = 3'd4
  } src_e;

  localparam int SRC_N = 5;

  // capture mode chooses between the two channel lines; waveform mode adds the extra lines
  function automatic src_e pick_src(input logic wave, input logic [1:0] sel);
    src_e r;
    if (!wave) begin
      r = sel[0] ? SRC_B : SRC_A;
    end else begin
      case (sel)
        2'd0:    r = SRC_B;
        2'd1:    r = SRC_X0;
        2'd2:    r = SRC_X1;
        default: r = SRC_X2;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wave,
  input  logic [1:0] sel,
  input  logic       en,
  input  logic       line_a,
  input  logic       line_b,
  input  logic [2:0] xc,
  output logic       ext_req
);
  import tmr_pkg::*;

  logic [SRC_N-1:0] srcs;
  logic             picked;
  logic [STAGES-1:0] chain;
  logic             last_q;

  assign srcs   = {xc, line_b, line_a};
  assign picked = srcs[pick_src(wave, sel)];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= picked;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign ext_req = en && chain[STAGES-1] && !last_q;
endmodule

// File: rtl/tmr_clk_gate.sv
module tmr_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic dis_evt,
  input  logic stop_evt,
  input  logic fire,
  output logic run_q,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      // disable has priority over enable
      if (cmd_dis || dis_evt) run_q <= 1'b0;
      else if (cmd_en)        run_q <= 1'b1;
      if (stop_evt)  halt_q <= 1'b1;
      else if (fire) halt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_trig_ctl.sv
module tmr_trig_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_now,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rc,
  input  logic             tick,
  input  logic             run,
  output logic             fire
);
  logic pend_q;
  logic cmp_hit;

  assign cmp_hit = cmp_en && (cnt == rc);
  // a request raised in the tick's own cycle is merged into that tick
  assign fire    = tick && run && (pend_q || req_now || cmp_hit);

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (fire)    pend_q <= 1'b0;
    else if (req_now) pend_q <= 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || fire) cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/tmr_chan_front.sv
module tmr_chan_front #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wave,
  input  logic [1:0]       ext_sel,
  input  logic             ext_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] rc_val,
  input  logic             cmd_clk_en,
  input  logic             cmd_clk_dis,
  input  logic             cmd_sw_trig,
  input  logic             sync_in,
  input  logic             stop_evt,
  input  logic             dis_evt,
  input  logic             cnt_tick,
  input  logic             line_a_in,
  input  logic             line_b_in,
  input  logic [2:0]       xc_in,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_on,
  output logic             line_a_oe,
  output logic             line_b_oe
);
  logic ext_req, req_now, fire, halt, adv;

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .wave(mode_wave), .sel(ext_sel), .en(ext_en),
    .line_a(line_a_in), .line_b(line_b_in), .xc(xc_in), .ext_req(ext_req)
  );

  assign req_now = cmd_sw_trig || sync_in || ext_req;

  tmr_trig_ctl #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst(rst), .req_now(req_now), .cmp_en(cmp_en), .cnt(cnt),
    .rc(rc_val), .tick(cnt_tick), .run(clk_on), .fire(fire)
  );

  tmr_clk_gate u_gate (
    .clk(clk), .rst(rst), .cmd_en(cmd_clk_en), .cmd_dis(cmd_clk_dis),
    .dis_evt(dis_evt), .stop_evt(stop_evt), .fire(fire),
    .run_q(clk_on), .halt_q(halt)
  );

  assign adv = cnt_tick && clk_on && !halt;

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .fire(fire), .adv(adv), .cnt_q(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_a_oe <= 1'b0;
      line_b_oe <= 1'b0;
    end else begin
      line_a_oe <= mode_wave;
      line_b_oe <= mode_wave && (ext_sel != 2'd0);
    end
  end
endmodule

// File: rtl/tmr_chan_front_chk.sv
module tmr_chan_front_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_wave,
  input logic             cmp_en,
  input logic [CNT_W-1:0] rc_val,
  input logic             cmd_clk_en,
  input logic             cmd_clk_dis,
  input logic             cmd_sw_trig,
  input logic             dis_evt,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] cnt,
  input logic             clk_on,
  input logic             line_a_oe,
  input logic             line_b_oe
);
  a_r2_dis_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_clk_dis || dis_evt) |=> !clk_on);

  a_r2_en_sets: assert property (@(posedge clk) disable iff (rst)
    (cmd_clk_en && !cmd_clk_dis && !dis_evt) |=> clk_on);

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !cnt_tick |=> (cnt == $past(cnt)));

  a_r3_hold_clk_off: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !clk_on) |=> (cnt == $past(cnt)));

  a_r4_sw_at_tick: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && clk_on && cmd_sw_trig) |=> (cnt == '0));

  a_r6_cmp_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && clk_on && cmp_en && cnt == rc_val) |=> (cnt == '0));

  a_r9_capture_inputs: assert property (@(posedge clk) disable iff (rst)
    !mode_wave |=> (!line_a_oe && !line_b_oe));

  a_r9_wave_a_out: assert property (@(posedge clk) disable iff (rst)
    mode_wave |=> line_a_oe);
endmodule

bind tmr_chan_front tmr_chan_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_wave(mode_wave), .cmp_en(cmp_en),
  .rc_val(rc_val), .cmd_clk_en(cmd_clk_en), .cmd_clk_dis(cmd_clk_dis),
  .cmd_sw_trig(cmd_sw_trig), .dis_evt(dis_evt), .cnt_tick(cnt_tick),
  .cnt(cnt), .clk_on(clk_on), .line_a_oe(line_a_oe), .line_b_oe(line_b_oe)
);

// File: tb/test_tmr_chan_front.sv
`timescale 1ns/1ps
module test_tmr_chan_front;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wave = 0, ext_en = 0, cmp_en = 0;
  logic [1:0] ext_sel = 0;
  logic [W-1:0] rc_val = 0;
  logic cmd_clk_en = 0, cmd_clk_dis = 0, cmd_sw_trig = 0, sync_in = 0;
  logic stop_evt = 0, dis_evt = 0, cnt_tick = 0;
  logic line_a_in = 0, line_b_in = 0;
  logic [2:0] xc_in = 0;
  logic [W-1:0] cnt;
  logic clk_on, line_a_oe, line_b_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_chan_front #(.CNT_W(W)) i_tmr_chan_front (
    .clk(clk), .rst(rst), .mode_wave(mode_wave), .ext_sel(ext_sel),
    .ext_en(ext_en), .cmp_en(cmp_en), .rc_val(rc_val),
    .cmd_clk_en(cmd_clk_en), .cmd_clk_dis(cmd_clk_dis),
    .cmd_sw_trig(cmd_sw_trig), .sync_in(sync_in), .stop_evt(stop_evt),
    .dis_evt(dis_evt), .cnt_tick(cnt_tick), .line_a_in(line_a_in),
    .line_b_in(line_b_in), .xc_in(xc_in), .cnt(cnt), .clk_on(clk_on),
    .line_a_oe(line_a_oe), .line_b_oe(line_b_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1;
    repeat (n) cyc();
    cnt_tick = 0;
  endtask

  task automatic zero();
    cmd_sw_trig = 1; cnt_tick = 1;
    cyc();
    cmd_sw_trig = 0; cnt_tick = 0;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: line_a_in = v;
      1: line_b_in = v;
      2: xc_in[0] = v;
      3: xc_in[1] = v;
      default: xc_in[2] = v;
    endcase
  endtask

  // source index per R7: 0=line A, 1=line B, 2..4 = xc[0..2]
  function automatic int want_src(input int m, input int sel);
    if (m == 0) return sel % 2;
    return (sel == 0) ? 1 : sel + 1;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e;
    @(negedge clk);
    repeat (3) cyc();
    chk("R1 cnt in reset", cnt, 0);
    chk("R1 clk_on in reset", clk_on, 0);
    chk("R1 oe_a in reset", line_a_oe, 0);
    chk("R1 oe_b in reset", line_b_oe, 0);
    rst = 0;
    cyc();

    // R3: ticks with clock disabled do nothing
    ticks(5);
    chk("R3 no count while off", cnt, 0);

    // R2 enable/disable latch
    cmd_clk_en = 1; cmd_clk_dis = 1; cyc(); cmd_clk_en = 0; cmd_clk_dis = 0;
    chk("R2 disable wins", clk_on, 0);
    cmd_clk_en = 1; cyc(); cmd_clk_en = 0;
    chk("R2 enable sets", clk_on, 1);
    dis_evt = 1; cyc(); dis_evt = 0;
    chk("R2 disable event clears", clk_on, 0);
    cmd_clk_en = 1; cyc(); cmd_clk_en = 0;
    cmd_clk_dis = 1; cyc(); cmd_clk_dis = 0;
    chk("R2 disable command clears", clk_on, 0);
    cmd_clk_en = 1; cyc(); cmd_clk_en = 0;

    // R3 counting under tick patterns of period 1..4
    for (int k = 1; k <= 4; k++) begin
      zero();
      e = 0;
      for (int c = 0; c < 12; c++) begin
        cnt_tick = (c % k == 0);
        if (c % k == 0) e++;
        cyc();
        chk($sformatf("R3 pattern k=%0d c=%0d", k, c), cnt, e);
      end
      cnt_tick = 0;
    end

    // R3 wrap
    zero();
    ticks(255);
    chk("R3 reaches max", cnt, 255);
    ticks(1);
    chk("R3 wraps to zero", cnt, 0);

    // R4 software trigger deferral
    zero(); ticks(6);
    cmd_sw_trig = 1; cyc(); cmd_sw_trig = 0;
    repeat (3) cyc();
    chk("R4 sw trigger waits for tick", cnt, 6);
    ticks(1);
    chk("R4 sw trigger clears at tick", cnt, 0);
    ticks(1);
    chk("R4 counts after trigger", cnt, 1);

    // R5 sync pulse
    zero(); ticks(4);
    sync_in = 1; cyc(); sync_in = 0;
    cyc();
    chk("R5 sync waits for tick", cnt, 4);
    ticks(1);
    chk("R5 sync clears at tick", cnt, 0);

    // R6 compare sweep
    for (int rc = 0; rc < 8; rc++) begin
      rc_val = W'(rc); cmp_en = 1;
      zero();
      for (int i = 1; i <= 20; i++) begin
        ticks(1);
        chk($sformatf("R6 rc=%0d step=%0d", rc, i), cnt, i % (rc + 1));
      end
      cmp_en = 0;
      zero(); ticks(rc + 3);
      chk($sformatf("R6 disabled rc=%0d", rc), cnt, rc + 3);
    end

    // R7 external source selection
    for (int m = 0; m < 2; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        mode_wave = m[0]; ext_sel = sel[1:0]; ext_en = 1;
        repeat (4) cyc();
        for (int s = 0; s < 5; s++) begin
          zero(); ticks(3);
          set_src(s, 1); repeat (4) cyc();
          set_src(s, 0); repeat (4) cyc();
          chk($sformatf("R7 deferred m=%0d sel=%0d src=%0d", m, sel, s), cnt, 3);
          ticks(1);
          chk($sformatf("R7 m=%0d sel=%0d src=%0d", m, sel, s), cnt,
              (s == want_src(m, sel)) ? 0 : 4);
        end
        ext_en = 0;
        zero(); ticks(3);
        set_src(want_src(m, sel), 1); repeat (4) cyc();
        set_src(want_src(m, sel), 0); repeat (4) cyc();
        ticks(1);
        chk($sformatf("R7 ext disabled m=%0d sel=%0d", m, sel), cnt, 4);
      end
    end
    mode_wave = 0; ext_sel = 0;

    // R8 stop event
    zero(); ticks(2);
    stop_evt = 1; cyc(); stop_evt = 0;
    ticks(3);
    chk("R8 frozen after stop", cnt, 2);
    cmd_sw_trig = 1; cyc(); cmd_sw_trig = 0;
    chk("R8 trigger waits", cnt, 2);
    ticks(1);
    chk("R8 trigger clears", cnt, 0);
    ticks(2);
    chk("R8 resumes", cnt, 2);

    // R10 trigger pending across disabled clock
    zero(); ticks(5);
    cmd_clk_dis = 1; cyc(); cmd_clk_dis = 0;
    cmd_sw_trig = 1; cyc(); cmd_sw_trig = 0;
    ticks(3);
    chk("R10 held while off", cnt, 5);
    cmd_clk_en = 1; cyc(); cmd_clk_en = 0;
    ticks(1);
    chk("R10 pending applied after enable", cnt, 0);

    // R9 output enables
    for (int m = 0; m < 2; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        mode_wave = m[0]; ext_sel = sel[1:0];
        cyc();
        chk($sformatf("R9 oe_a m=%0d sel=%0d", m, sel), line_a_oe, m);
        chk($sformatf("R9 oe_b m=%0d sel=%0d", m, sel), line_b_oe,
            (m == 1 && sel != 0) ? 1 : 0);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule